// File: doc/BRIEF.md
# Hall-Sensor Commutation Decoder for a Three-Phase Brushless Motor

This block turns the three position-sensor bits of a three-phase brushless DC motor into six bridge-switch enables. Three outputs switch the high-side devices of phases A, B and C. The other three switch the low-side devices. Each output is a logical "switch on" level. The polarity that a particular gate driver needs is applied outside the block.

A 2-bit spacing select tells the decoder how far apart the sensors sit electrically. A direction input reverses the rotation. An enable input gates conduction and may be driven as a PWM chop. A brake input shorts the windings through the low-side switches. An over-current input blanks the bridge at once. Every input passes through a two-stage synchronizer, and the six outputs come from a register.

Top module: `bldc_hall_commutator`

## Requirements
- R1: Every input passes through two synchronizer flops and the outputs are registered. A change on an input that is stable before rising edge k shows at the outputs just after rising edge k+2, and not earlier.
- R2: With spacing select 2'b01 (120°) and direction 1 (forward), the sensor codes {S3,S2,S1} = 001, 011, 010, 110, 100, 101 give the steps 0 to 5. The high/low pairs for steps 0 to 5 are A/B, A/C, B/C, B/A, C/A and C/B. On each output bus, phase A is bit 0, B is bit 1 and C is bit 2.
- R3: Direction 0 (reverse) swaps the high-side and low-side assignment of every step.
- R4: Spacing select 2'b00 (60°) maps the codes 000, 001, 011, 111, 110, 100 to steps 0 to 5. Codes 010 and 101 are invalid for this spacing.
- R5: Spacing select 2'b10 (240°) uses the 120° table, and 2'b11 (300°) uses the 60° table. In both cases the code is first bit-reversed to {S1,S2,S3}.
- R6: A code that is invalid for the selected spacing turns all six outputs off. For 120° spacing the invalid codes are 000 and 111.
- R7: While the enable input is low, all six outputs are off.
- R8: A high brake input drives all high-side outputs off and all low-side outputs on. Brake takes priority over direction, enable, over-current, spacing and the sensor code.
- R9: A high over-current input turns all outputs off. Conduction resumes only after over-current is low and the enable input then shows a rising edge.
- R10: No output state ever enables the high-side and low-side switch of the same phase together. Outside of braking, at most one high-side output and at most one low-side output is on.
- R11: After reset, all six outputs are off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hall_code | input | 3 | Sensor bits {S3,S2,S1} |
| spacing_sel | input | 2 | 00 = 60°, 01 = 120°, 10 = 240°, 11 = 300° |
| dir_fwd | input | 1 | 1 = forward, 0 = reverse |
| drive_en | input | 1 | Conduction enable / PWM chop |
| brake | input | 1 | Winding short request, highest priority |
| over_current | input | 1 | Over-current sense, blanks the bridge |
| hs_on | output | 3 | High-side switch enables, bit 0 = phase A |
| ls_on | output | 3 | Low-side switch enables, bit 0 = phase A |

## Verification
The assertions check on every cycle that a phase never has both of its switches on and that the brake pattern follows a synchronized brake request. They also check that low enable, a pending over-current or an invalid code each leave the bridge dark in the next cycle. Only the bench scenarios can show that the tables are correct for each spacing and direction, since the assertions do not hold the expected step for each code. The same applies to the exact three-edge latency and to the rule that an over-current lockout is lifted only by a fresh enable edge.

// File: rtl/bldc_comm_pkg.sv
package bldc_comm_pkg;

    localparam int PHASES  = 3;
    localparam int CODE_W  = 3;
    localparam int STEPS   = 6;
    localparam int STEP_W  = $clog2(STEPS);

    typedef enum logic [1:0] {
        SPACE_60  = 2'b00,
        SPACE_120 = 2'b01,
        SPACE_240 = 2'b10,
        SPACE_300 = 2'b11
    } spacing_e;

    typedef struct packed {
        logic [PHASES-1:0] hi;
        logic [PHASES-1:0] lo;
    } bridge_t;

    typedef struct packed {
        logic              valid;
        logic [STEP_W-1:0] step;
    } step_t;

    localparam bridge_t BRIDGE_OFF   = '{hi: '0, lo: '0};
    localparam bridge_t BRIDGE_BRAKE = '{hi: '0, lo: '1};

    function automatic logic [CODE_W-1:0] rev_code(input logic [CODE_W-1:0] c);
        logic [CODE_W-1:0] r;
        for (int i = 0; i < CODE_W; i++) r[i] = c[CODE_W-1-i];
        return r;
    endfunction

    function automatic step_t step_wide(input logic [CODE_W-1:0] c);
        step_t s;
        s.valid = 1'b1;
        unique case (c)
            3'b001:  s.step = 3'd0;
            3'b011:  s.step = 3'd1;
            3'b010:  s.step = 3'd2;
            3'b110:  s.step = 3'd3;
            3'b100:  s.step = 3'd4;
            3'b101:  s.step = 3'd5;
            default: begin s.valid = 1'b0; s.step = '0; end
        endcase
        return s;
    endfunction

    function automatic step_t step_narrow(input logic [CODE_W-1:0] c);
        step_t s;
        s.valid = 1'b1;
        unique case (c)
            3'b000:  s.step = 3'd0;
            3'b001:  s.step = 3'd1;
            3'b011:  s.step = 3'd2;
            3'b111:  s.step = 3'd3;
            3'b110:  s.step = 3'd4;
            3'b100:  s.step = 3'd5;
            default: begin s.valid = 1'b0; s.step = '0; end
        endcase
        return s;
    endfunction

    function automatic bridge_t step_to_bridge(input logic [STEP_W-1:0] st,
                                               input logic fwd);
        bridge_t b;
        int unsigned src, snk;
        src = int'(st) >> 1;
        snk = (((int'(st) + 1) >> 1) + 1) % PHASES;
        b = BRIDGE_OFF;
        if (fwd) begin
            b.hi[src] = 1'b1;
            b.lo[snk] = 1'b1;
        end else begin
            b.hi[snk] = 1'b1;
            b.lo[src] = 1'b1;
        end
        return b;
    endfunction

endpackage

// File: rtl/comm_sync.sv
module comm_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else if (g == 0) chain[g] <= d;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/comm_step_decode.sv
module comm_step_decode
    import bldc_comm_pkg::*;
(
    input  spacing_e            sel,
    input  logic [CODE_W-1:0]   code,
    output step_t               step
);
    logic [CODE_W-1:0] code_eff;

    always_comb begin
        code_eff = (sel == SPACE_240 || sel == SPACE_300) ? rev_code(code) : code;
        unique case (sel)
            SPACE_120, SPACE_240: step = step_wide(code_eff);
            default:              step = step_narrow(code_eff);
        endcase
    end
endmodule

// File: rtl/comm_ovc_guard.sv
module comm_ovc_guard (
    input  logic clk,
    input  logic rst,
    input  logic oc,
    input  logic en,
    output logic block
);
    logic latched_q;
    logic en_prev_q;
    logic en_rise;

    assign en_rise = en & ~en_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            latched_q <= 1'b0;
            en_prev_q <= 1'b0;
        end else begin
            en_prev_q <= en;
            if (oc)           latched_q <= 1'b1;
            else if (en_rise) latched_q <= 1'b0;
        end
    end

    assign block = oc | latched_q;
endmodule

// File: rtl/bldc_hall_commutator.sv
module bldc_hall_commutator
    import bldc_comm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_code,
    input  logic [1:0] spacing_sel,
    input  logic       dir_fwd,
    input  logic       drive_en,
    input  logic       brake,
    input  logic       over_current,
    output logic [2:0] hs_on,
    output logic [2:0] ls_on
);
    localparam int LOW_W = CODE_W + 2 + 3;

    logic [LOW_W-1:0] raw_low, syn_low;
    logic             dir_s;
    logic [CODE_W-1:0] code_s;
    spacing_e         sel_s;
    logic             en_s, brk_s, oc_s;
    logic             oc_block;
    step_t            step;
    bridge_t          next_b, bridge_q;

    assign raw_low = {hall_code, spacing_sel, drive_en, brake, over_current};

    comm_sync #(.W(LOW_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_low (
        .clk(clk), .rst(rst), .d(raw_low), .q(syn_low)
    );

    comm_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dir (
        .clk(clk), .rst(rst), .d(dir_fwd), .q(dir_s)
    );

    assign code_s = syn_low[LOW_W-1 -: CODE_W];
    assign sel_s  = spacing_e'(syn_low[4:3]);
    assign en_s   = syn_low[2];
    assign brk_s  = syn_low[1];
    assign oc_s   = syn_low[0];

    comm_step_decode u_dec (
        .sel(sel_s), .code(code_s), .step(step)
    );

    comm_ovc_guard u_ovc (
        .clk(clk), .rst(rst), .oc(oc_s), .en(en_s), .block(oc_block)
    );

    always_comb begin
        if (brk_s)                            next_b = BRIDGE_BRAKE;
        else if (!en_s || oc_block || !step.valid) next_b = BRIDGE_OFF;
        else                                  next_b = step_to_bridge(step.step, dir_s);
    end

    always_ff @(posedge clk) begin
        if (rst) bridge_q <= BRIDGE_OFF;
        else     bridge_q <= next_b;
    end

    assign hs_on = bridge_q.hi;
    assign ls_on = bridge_q.lo;
endmodule

// File: rtl/bldc_hall_commutator_chk.sv
module bldc_hall_commutator_chk (
    input logic       clk,
    input logic       rst,
    input logic       brk_s,
    input logic       en_s,
    input logic       oc_block,
    input logic       code_ok,
    input logic [2:0] hs_on,
    input logic [2:0] ls_on
);
    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (hs_on & ls_on) == 3'b000);                                   // R10

    AST_SINGLE_PAIR: assert property (@(posedge clk) disable iff (rst)
        (ls_on != 3'b111) |-> ($countones(hs_on) <= 1 && $countones(ls_on) <= 1)); // R10

    AST_BRAKE_PATTERN: assert property (@(posedge clk) disable iff (rst)
        brk_s |=> (hs_on == 3'b000 && ls_on == 3'b111));              // R8

    AST_ENABLE_LOW_DARK: assert property (@(posedge clk) disable iff (rst)
        (!brk_s && !en_s) |=> (hs_on == 3'b000 && ls_on == 3'b000));  // R7

    AST_OVC_DARK: assert property (@(posedge clk) disable iff (rst)
        (!brk_s && oc_block) |=> (hs_on == 3'b000 && ls_on == 3'b000)); // R9

    AST_INVALID_DARK: assert property (@(posedge clk) disable iff (rst)
        (!brk_s && !code_ok) |=> (hs_on == 3'b000 && ls_on == 3'b000)); // R6
endmodule

bind bldc_hall_commutator bldc_hall_commutator_chk u_chk (
    .clk(clk), .rst(rst), .brk_s(brk_s), .en_s(en_s), .oc_block(oc_block),
    .code_ok(step.valid), .hs_on(hs_on), .ls_on(ls_on)
);

// File: tb/sim_bldc_hall_commutator.sv
module sim_bldc_hall_commutator;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] hall_code;
    logic [1:0] spacing_sel;
    logic       dir_fwd, drive_en, brake, over_current;
    logic [2:0] hs_on, ls_on;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    bldc_hall_commutator u0 (
        .clk(clk), .rst(rst), .hall_code(hall_code), .spacing_sel(spacing_sel),
        .dir_fwd(dir_fwd), .drive_en(drive_en), .brake(brake),
        .over_current(over_current), .hs_on(hs_on), .ls_on(ls_on)
    );

    // Expected pairs for forward steps 0..5: {hi,lo}
    function automatic logic [5:0] pair_of(input int st, input logic fwd);
        logic [2:0] h, l;
        case (st)
            0: begin h = 3'b001; l = 3'b010; end
            1: begin h = 3'b001; l = 3'b100; end
            2: begin h = 3'b010; l = 3'b100; end
            3: begin h = 3'b010; l = 3'b001; end
            4: begin h = 3'b100; l = 3'b001; end
            default: begin h = 3'b100; l = 3'b010; end
        endcase
        return fwd ? {h, l} : {l, h};
    endfunction

    function automatic int step_120(input logic [2:0] c);
        case (c)
            3'b001: return 0; 3'b011: return 1; 3'b010: return 2;
            3'b110: return 3; 3'b100: return 4; 3'b101: return 5;
            default: return -1;
        endcase
    endfunction

    function automatic int step_60(input logic [2:0] c);
        case (c)
            3'b000: return 0; 3'b001: return 1; 3'b011: return 2;
            3'b111: return 3; 3'b110: return 4; 3'b100: return 5;
            default: return -1;
        endcase
    endfunction

    function automatic logic [5:0] expect_out(input logic [1:0] sel,
                                              input logic [2:0] c, input logic fwd);
        logic [2:0] cc;
        int st;
        cc = sel[1] ? {c[0], c[1], c[2]} : c;
        st = (sel == 2'b01 || sel == 2'b10) ? step_120(cc) : step_60(cc);
        if (st < 0) return 6'b000000;
        return pair_of(st, fwd);
    endfunction

    task automatic check(input string req, input logic [5:0] exp);
        n_chk++;
        if ({hs_on, ls_on} !== exp) begin
            n_fail++;
            $display("FAIL %s: got hs=%b ls=%b expected hs=%b ls=%b",
                     req, hs_on, ls_on, exp[5:3], exp[2:0]);
        end
    endtask

    task automatic settle(input int n = 4);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [1:0] sel, input logic [2:0] c, input logic fwd);
        @(negedge clk);
        spacing_sel = sel; hall_code = c; dir_fwd = fwd;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; drive_en = 1'b1; brake = 1'b0; over_current = 1'b0;
        spacing_sel = 2'b01; hall_code = 3'b001; dir_fwd = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset", 6'b000000);
        rst = 1'b0;
        settle();
    endtask

    task automatic t_latency_r1();
        drive(2'b01, 3'b001, 1'b1);
        settle();
        check("R1 base", 6'b001_010);
        drive(2'b01, 3'b011, 1'b1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 not before third edge", 6'b001_010);
        @(posedge clk);
        @(negedge clk);
        check("R1 third edge", 6'b001_100);
    endtask

    task automatic t_sweep(input logic [1:0] sel, input logic fwd, input string req);
        for (int c = 0; c < 8; c++) begin
            drive(sel, 3'(c), fwd);
            settle();
            check(req, expect_out(sel, 3'(c), fwd));
            n_chk++;
            if ((hs_on & ls_on) != 3'b000) begin
                n_fail++;
                $display("FAIL R10: same-phase overlap hs=%b ls=%b expected no overlap", hs_on, ls_on);
            end
        end
    endtask

    task automatic t_invalid_r6();
        drive(2'b01, 3'b000, 1'b1); settle(); check("R6 code 000 at 120", 6'b0);
        drive(2'b01, 3'b111, 1'b1); settle(); check("R6 code 111 at 120", 6'b0);
        drive(2'b00, 3'b010, 1'b1); settle(); check("R6 code 010 at 60", 6'b0);
    endtask

    task automatic t_enable_r7();
        drive(2'b01, 3'b010, 1'b1);
        settle();
        check("R7 enabled", 6'b010_100);
        @(negedge clk); drive_en = 1'b0;
        settle();
        check("R7 enable low", 6'b0);
        @(negedge clk); drive_en = 1'b1;
        settle();
        check("R7 enable back", 6'b010_100);
    endtask

    task automatic t_brake_r8();
        drive(2'b01, 3'b110, 1'b0);
        @(negedge clk); brake = 1'b1;
        settle();
        check("R8 brake", 6'b000_111);
        @(negedge clk); drive_en = 1'b0; over_current = 1'b1; hall_code = 3'b111;
        settle();
        check("R8 brake priority", 6'b000_111);
        @(negedge clk); brake = 1'b0; over_current = 1'b0; hall_code = 3'b110;
        settle();
        @(negedge clk); drive_en = 1'b1;
        settle(6);
        check("R8 brake release", pair_of(3, 1'b0));
    endtask

    task automatic t_ovc_r9();
        drive(2'b01, 3'b100, 1'b1);
        settle();
        check("R9 before fault", 6'b100_001);
        @(negedge clk); over_current = 1'b1;
        settle();
        check("R9 fault dark", 6'b0);
        @(negedge clk); over_current = 1'b0;
        settle(8);
        check("R9 stays dark without enable edge", 6'b0);
        @(negedge clk); drive_en = 1'b0;
        settle();
        @(negedge clk); drive_en = 1'b1;
        settle(6);
        check("R9 rearmed by enable edge", 6'b100_001);
    endtask

    initial begin
        rst = 1'b1; hall_code = '0; spacing_sel = '0; dir_fwd = 1'b1;
        drive_en = 1'b0; brake = 1'b0; over_current = 1'b0;
        t_reset();
        t_latency_r1();
        t_sweep(2'b01, 1'b1, "R2 120 fwd");
        t_sweep(2'b01, 1'b0, "R3 120 rev");
        t_sweep(2'b00, 1'b1, "R4 60 fwd");
        t_sweep(2'b00, 1'b0, "R4 R3 60 rev");
        t_sweep(2'b10, 1'b1, "R5 240 fwd");
        t_sweep(2'b11, 1'b0, "R5 300 rev");
        t_invalid_r6();
        t_enable_r7();
        t_brake_r8();
        t_ovc_r9();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule